// File: doc/BRIEF.md
# Dual-Modulus Integer-N Feedback and Reference Divider

This block holds the digital counters of an integer-N frequency synthesizer. On the fast input clock it runs a dual-modulus prescaler (divide by P or P+1, where P is 5 or 10) together with a swallow counter and a main counter. The result is one feedback pulse `fp` for every P·(M+1)+A input cycles. A bypass setting takes the prescaler out of the path, and the input clock is then divided by M+1 directly. A separate reference counter on the reference clock produces the comparison pulse `fc` once every R+1 reference cycles.

The modulus the prescaler uses for its current cycle is brought out as `msel`. Divide values and mode bits are sampled only when a division period ends. A new setting can therefore be applied at any time without cutting short the period in progress.

Reset is synchronous and active-high. It is sampled in each clock domain on that domain's own edges.

Top module: `feedback_divider_chain`

## Requirements
- R1: With bypass low and `mod_five` low (P=10), the time from one `fp` pulse to the next is 10·(M+1)+A cycles of `clk_vco`, for 1 ≤ M ≤ 511 and A ≤ M+1.
- R2: With bypass low and `mod_five` high (P=5), the time from one `fp` pulse to the next is 5·(M+1)+A cycles of `clk_vco`.
- R3: With `bypass_presc` high, the `fp` period is M+1 cycles of `clk_vco`, and `a_val` and `mod_five` have no effect on it.
- R4: With `bypass_presc` high, `msel` stays low.
- R5: In prescaler mode, `msel` is high for the first A prescaler cycles of each period, each of which lasts P+1 input cycles. Over one period it is therefore high for A·(P+1) cycles of `clk_vco`.
- R6: The `fc` period is R+1 cycles of `clk_ref`, for 0 ≤ R ≤ 63.
- R7: With R=0, `fc` is high in every `clk_ref` cycle, so the reference passes through undivided.
- R8: `fp` is a pulse one `clk_vco` cycle wide. Two consecutive periods measured under a fixed setting are equal.
- R9: A change of M, A, mode or R made in the middle of a period leaves that period at its old length. The next period uses the new values.
- R10: While `rst` is high, `fp`, `fc` and `msel` are low. The cycle after reset is released, `fp` pulses and the divider loads its setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast input clock to be divided |
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow count A |
| r_val | input | 6 | Reference counter value R |
| bypass_presc | input | 1 | High: prescaler and swallow counter unused, divide by M+1 |
| mod_five | input | 1 | High: 5/6 modulus; low: 10/11 modulus |
| fp | output | 1 | Feedback pulse, one `clk_vco` cycle per period |
| fc | output | 1 | Reference pulse, one `clk_ref` cycle per period |
| msel | output | 1 | High while the prescaler divides by P+1 |

## Verification
The bench builds the block with its default widths: 9-bit M, 4-bit A and 6-bit R. It sweeps every legal A for M from 1 to 7 in both prescaler moduli, and adds the largest M with the largest A. It also runs bypass for M from 1 to 8 and at 511, and runs the reference counter over R from 0 to 12 and at 63. With these small settings every swallow count up to M+1 can be reached, as can the corner where A equals M+1 and the undivided reference. Mid-period changes to both counters confirm that a running period always completes at its old length.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int R_W    = 6;
    localparam int P_LOW  = 5;
    localparam int P_HIGH = 10;
    localparam int PC_W   = $clog2(P_HIGH + 1);

    typedef enum logic [1:0] {
        MODE_TEN    = 2'd0,
        MODE_FIVE   = 2'd1,
        MODE_BYPASS = 2'd2
    } div_mode_e;

    typedef struct packed {
        div_mode_e        mode;
        logic [M_W-1:0]   m;
        logic [A_W-1:0]   a;
    } fb_cfg_t;

    function automatic div_mode_e decode_mode(input logic bypass, input logic five);
        if (bypass)    return MODE_BYPASS;
        else if (five) return MODE_FIVE;
        else           return MODE_TEN;
    endfunction

    // Reload value of the prescaler down-counter: cycle length minus one.
    function automatic logic [PC_W-1:0] presc_load(input div_mode_e mode, input logic long_cyc);
        logic [PC_W-1:0] base;
        case (mode)
            MODE_FIVE: base = PC_W'(P_LOW - 1);
            MODE_TEN:  base = PC_W'(P_HIGH - 1);
            default:   base = '0;
        endcase
        if (mode != MODE_BYPASS && long_cyc) base = base + 1'b1;
        return base;
    endfunction

endpackage

// File: rtl/presc_core.sv
module presc_core
    import pll_div_pkg::*;
#(
    parameter int CW = PC_W
) (
    input  logic      clk,
    input  logic      rst,
    input  div_mode_e mode_nxt,
    input  logic      long_nxt,
    output logic      tick
);

    logic [CW-1:0] pcnt;

    assign tick = (pcnt == '0);

    always_ff @(posedge clk) begin
        if (rst)        pcnt <= '0;
        else if (tick)  pcnt <= CW'(presc_load(mode_nxt, long_nxt));
        else            pcnt <= pcnt - 1'b1;
    end

    assert_presc_reset_R10: assert property (@(posedge clk) rst |=> (pcnt == '0));

    assert_bypass_every_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && mode_nxt == MODE_BYPASS) |=> tick);

endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
    import pll_div_pkg::*;
#(
    parameter int MW = M_W,
    parameter int AW = A_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [MW-1:0]   m_in,
    input  logic [AW-1:0]   a_in,
    input  div_mode_e       mode_in,
    output div_mode_e       mode_nxt,
    output logic            long_nxt,
    output logic            fp,
    output logic            msel
);

    logic [MW-1:0] m_cnt, m_n;
    logic [AW-1:0] a_cnt, a_n;
    div_mode_e     mode_q;
    logic          period_end;

    assign period_end = tick && (m_cnt == '0);

    always_comb begin
        m_n      = m_cnt;
        a_n      = a_cnt;
        mode_nxt = mode_q;
        if (period_end) begin
            m_n      = m_in;
            a_n      = (mode_in == MODE_BYPASS) ? '0 : a_in;
            mode_nxt = mode_in;
        end else if (tick) begin
            m_n = m_cnt - 1'b1;
            a_n = (a_cnt != '0) ? a_cnt - 1'b1 : '0;
        end
    end

    assign long_nxt = (a_n != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_cnt  <= '0;
            a_cnt  <= '0;
            mode_q <= MODE_TEN;
            msel   <= 1'b0;
            fp     <= 1'b0;
        end else begin
            m_cnt <= m_n;
            a_cnt <= a_n;
            msel  <= long_nxt;
            fp    <= period_end;
            if (period_end) mode_q <= mode_in;
        end
    end

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!msel && !fp && m_cnt == '0));

    assert_msel_moves_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(msel) || $fell(msel)) |-> $past(tick));

    assert_bypass_no_msel_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_nxt == MODE_BYPASS) |=> !msel);

    assert_fp_single_R8: assert property (@(posedge clk) disable iff (rst)
        fp |=> !fp);

endmodule

// File: rtl/ref_div.sv
module ref_div
    import pll_div_pkg::*;
#(
    parameter int RW = R_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] r_in,
    output logic          fc
);

    logic [RW-1:0] r_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_cnt <= '0;
            fc    <= 1'b0;
        end else begin
            fc <= (r_cnt == '0);
            if (r_cnt == '0) r_cnt <= r_in;
            else             r_cnt <= r_cnt - 1'b1;
        end
    end

    assert_fc_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (fc && r_cnt != '0) |=> !fc);

    assert_ref_reset_R10: assert property (@(posedge clk) rst |=> !fc);

endmodule

// File: rtl/feedback_divider_chain.sv
module feedback_divider_chain
    import pll_div_pkg::*;
#(
    parameter int MW = M_W,
    parameter int AW = A_W,
    parameter int RW = R_W
) (
    input  logic          clk_vco,
    input  logic          clk_ref,
    input  logic          rst,
    input  logic [MW-1:0] m_val,
    input  logic [AW-1:0] a_val,
    input  logic [RW-1:0] r_val,
    input  logic          bypass_presc,
    input  logic          mod_five,
    output logic          fp,
    output logic          fc,
    output logic          msel
);

    fb_cfg_t   cfg_in;
    div_mode_e mode_nxt;
    logic      long_nxt;
    logic      tick;

    assign cfg_in.mode = decode_mode(bypass_presc, mod_five);
    assign cfg_in.m    = M_W'(m_val);
    assign cfg_in.a    = A_W'(a_val);

    presc_core u_presc (
        .clk      (clk_vco),
        .rst      (rst),
        .mode_nxt (mode_nxt),
        .long_nxt (long_nxt),
        .tick     (tick)
    );

    swallow_ctrl #(.MW(M_W), .AW(A_W)) u_swallow (
        .clk      (clk_vco),
        .rst      (rst),
        .tick     (tick),
        .m_in     (cfg_in.m),
        .a_in     (cfg_in.a),
        .mode_in  (cfg_in.mode),
        .mode_nxt (mode_nxt),
        .long_nxt (long_nxt),
        .fp       (fp),
        .msel     (msel)
    );

    ref_div #(.RW(RW)) u_ref (
        .clk  (clk_ref),
        .rst  (rst),
        .r_in (r_val),
        .fc   (fc)
    );

endmodule

// File: tb/feedback_divider_chain_tb.sv
`timescale 1ns/1ps
module feedback_divider_chain_tb;

    logic       clk_vco = 1'b0;
    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] m_val = 9'd1;
    logic [3:0] a_val = 4'd0;
    logic [5:0] r_val = 6'd0;
    logic       bypass_presc = 1'b0;
    logic       mod_five = 1'b0;
    logic       fp, fc, msel;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk_vco = ~clk_vco;
    always #7   clk_ref = ~clk_ref;

    feedback_divider_chain u_dut (
        .clk_vco(clk_vco), .clk_ref(clk_ref), .rst(rst),
        .m_val(m_val), .a_val(a_val), .r_val(r_val),
        .bypass_presc(bypass_presc), .mod_five(mod_five),
        .fp(fp), .fc(fc), .msel(msel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic meas_fb(output int per, output int ms);
        @(negedge clk_vco);
        while (!fp) @(negedge clk_vco);
        per = 0; ms = 0;
        do begin
            @(negedge clk_vco);
            per++;
            if (msel) ms++;
        end while (!fp);
    endtask

    task automatic meas_ref(output int per);
        @(negedge clk_ref);
        while (!fc) @(negedge clk_ref);
        per = 0;
        do begin
            @(negedge clk_ref);
            per++;
        end while (!fc);
    endtask

    function automatic int exp_ratio(input bit byp, input bit five, input int m, input int a);
        if (byp) return m + 1;
        return (five ? 5 : 10) * (m + 1) + a;
    endfunction

    task automatic run_fb(input bit byp, input bit five, input int m, input int a);
        int per, ms, er, em;
        string rq;
        bypass_presc = byp; mod_five = five;
        m_val = 9'(m); a_val = 4'(a);
        er = exp_ratio(byp, five, m, a);
        em = byp ? 0 : a * ((five ? 5 : 10) + 1);
        rq = byp ? "R3" : (five ? "R2" : "R1");
        meas_fb(per, ms);
        check(per == er, rq, per, er);
        check(ms == em, byp ? "R4" : "R5", ms, em);
        // second period right after the first: a wide fp pulse would shorten it (R8)
        per = 0;
        do begin
            @(negedge clk_vco);
            per++;
        end while (!fp);
        check(per == er, "R8", per, er);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_vco);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int per, ms;
        repeat (4) @(negedge clk_ref);
        // R10: outputs held low in reset
        check(fp == 1'b0,   "R10", fp,   0);
        check(msel == 1'b0, "R10", msel, 0);
        check(fc == 1'b0,   "R10", fc,   0);
        @(negedge clk_vco);
        rst = 1'b0;
        @(negedge clk_vco);
        check(fp == 1'b1, "R10", fp, 1);

        // R1 / R2 / R5: every legal A for small M, both moduli
        for (int five = 0; five < 2; five++)
            for (int m = 1; m <= 7; m++)
                for (int a = 0; a <= m + 1; a++)
                    run_fb(1'b0, five[0], m, a);
        run_fb(1'b0, 1'b0, 511, 15);
        run_fb(1'b0, 1'b1, 511, 15);

        // R3 / R4: bypass, A and modulus select must not matter
        for (int m = 1; m <= 8; m++)
            run_fb(1'b1, m[0], m, 15 - m);
        run_fb(1'b1, 1'b0, 511, 9);

        // R9: change mid-period, current period keeps its length
        run_fb(1'b0, 1'b0, 3, 2);
        per = 0;
        do begin
            @(negedge clk_vco);
            per++;
            if (per == 5) begin
                mod_five = 1'b1; m_val = 9'd2; a_val = 4'd1;
            end
        end while (!fp);
        check(per == 42, "R9", per, 42);
        per = 0;
        do begin
            @(negedge clk_vco);
            per++;
        end while (!fp);
        check(per == 16, "R9", per, 16);

        // R6 / R7: reference counter
        for (int r = 0; r <= 12; r++) begin
            r_val = 6'(r);
            meas_ref(per);
            check(per == r + 1, r == 0 ? "R7" : "R6", per, r + 1);
        end
        r_val = 6'd0;
        meas_ref(per);
        repeat (3) begin
            @(negedge clk_ref);
            check(fc == 1'b1, "R7", fc, 1);
        end
        r_val = 6'd63;
        meas_ref(per);
        check(per == 64, "R6", per, 64);

        // R9 on the reference side
        r_val = 6'd20;
        meas_ref(per);
        per = 0;
        do begin
            @(negedge clk_ref);
            per++;
            if (per == 3) r_val = 6'd2;
        end while (!fc);
        check(per == 21, "R9", per, 21);
        per = 0;
        do begin
            @(negedge clk_ref);
            per++;
        end while (!fc);
        check(per == 3, "R9", per, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule